// File: doc/BRIEF.md
# Cache Line Fill Buffer

This block sits between a cache's miss path and its memory port and handles read misses. A 64-byte (512-bit) line does not fit on the 128-bit return bus. So the block sends one burst read request for the whole line and collects the four 128-bit beats that come back. It assembles them in a small table of fill entries and writes the finished line into the cache data array with a single wide write.

Each of the four entries holds a line address, a mask of the beats received so far and the line being assembled. The memory request carries the entry index as its tag. Returned beats carry that tag and a beat index, so fills for different entries may interleave. Within one entry the beats arrive in order. A miss to a line that an entry already tracks is absorbed into that entry and costs no extra memory traffic.

The reset input is asynchronous active-low and is expected to be released synchronously to `clk` by the surrounding reset logic.

Top module: `lfb_top`

## Requirements
- R1: An accepted miss whose line is not held by a busy entry takes the lowest-numbered free entry. It produces exactly one memory request, with `mem_req_line` equal to the miss line and `mem_req_tag` equal to that entry's index.
- R2: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_line` and `mem_req_tag` do not change, even if other entries start waiting. When the port is free to choose, the lowest-numbered waiting entry is presented.
- R3: A miss whose line equals that of a busy entry is accepted and merged. It issues no memory request, and the line is written to the cache once.
- R4: `miss_ready` is low exactly when all four entries are busy. No miss is taken and no request is issued while it is low.
- R5: A beat with index k (`mem_rsp_beat` = k) lands in bits [128k+127:128k] of the line. The written line equals the four returned beats placed at those positions, including when beats of different entries interleave.
- R6: No cache write is made for an entry before all four of its beats are in. `cwr_valid` is high with that entry's line in the cycle after its fourth beat is accepted.
- R7: `cwr_valid` stays high until `cwr_ready` grants it. The entry becomes free after the granted write, and `miss_ready` returns high.
- R8: When several entries hold complete lines, `cwr_line` and `cwr_data` show the lowest-numbered one. The granted writes drain in ascending entry order.
- R9: Reset returns every entry to free, with `miss_ready` high, `mem_req_valid` low and `cwr_valid` low. After reset the next miss takes entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A read miss is presented |
| miss_ready | output | 1 | Block can take a miss (a free entry exists) |
| miss_line | input | 26 | Line address of the miss |
| mem_req_valid | output | 1 | Burst read request for a line is presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | 26 | Line address of the request |
| mem_req_tag | output | 2 | Entry index carried by the request |
| mem_rsp_valid | input | 1 | A returned beat is present |
| mem_rsp_tag | input | 2 | Entry index of the returned beat |
| mem_rsp_beat | input | 2 | Position of the beat within the line |
| mem_rsp_data | input | 128 | Beat data |
| cwr_valid | output | 1 | A complete line waits for the cache write port |
| cwr_ready | input | 1 | Write port grant |
| cwr_line | output | 26 | Line address of the write |
| cwr_data | output | 512 | Full assembled line |

## Verification
The bound checker watches handshake stability on both the request and write ports on every cycle. It tracks which tags are outstanding, so it can flag a second request for a line already in flight, a write whose line has not collected four beats under some tag, and a ready miss port while every tag is outstanding. Beat placement inside the line, the lowest-index choice of entry and of write, the merging of repeated misses and the state after a mid-fill reset can only be seen through the bench's scenarios. Those include a sweep over every completion order of four concurrent fills with the write port held off.

// File: rtl/lfb_pkg.sv
`timescale 1ns/1ps
package lfb_pkg;

  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_REQ   = 2'd1,
    ENT_FILL  = 2'd2,
    ENT_WRITE = 2'd3
  } ent_state_e;

endpackage

// File: rtl/lfb_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker: lowest set bit wins.
module lfb_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lfb_entry.sv
`timescale 1ns/1ps
// One fill entry: line address, beat mask and assembled line.
module lfb_entry
  import lfb_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int LINE_W = 512,
  parameter int BEAT_W = 128,
  parameter int BIDX_W = $clog2(LINE_W / BEAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_line_i,
  input  logic              req_done_i,
  input  logic              beat_we_i,
  input  logic [BIDX_W-1:0] beat_idx_i,
  input  logic [BEAT_W-1:0] beat_data_i,
  input  logic              wr_done_i,
  output ent_state_e        state_o,
  output logic [ADDR_W-1:0] line_o,
  output logic [LINE_W-1:0] data_o
);

  localparam int BEATS = LINE_W / BEAT_W;

  ent_state_e         state_q, state_d;
  logic [BEATS-1:0]   mask_q, mask_d;
  logic [ADDR_W-1:0]  line_q;
  logic [BEAT_W-1:0]  slice_q [BEATS];
  logic               line_en;

  // next state
  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    unique case (state_q)
      ENT_FREE: begin
        if (alloc_i) begin
          state_d = ENT_REQ;
          mask_d  = '0;
        end
      end
      ENT_REQ: begin
        if (req_done_i) state_d = ENT_FILL;
      end
      ENT_FILL: begin
        if (beat_we_i) begin
          mask_d[beat_idx_i] = 1'b1;
          if (&mask_d) state_d = ENT_WRITE;
        end
      end
      ENT_WRITE: begin
        if (wr_done_i) begin
          state_d = ENT_FREE;
          mask_d  = '0;
        end
      end
      default: state_d = ENT_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENT_FREE;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
    end
  end

  assign line_en = alloc_i && (state_q == ENT_FREE);

  always_ff @(posedge clk) begin
    if (line_en) line_q <= alloc_line_i;
  end

  // one storage slice per beat position
  for (genvar b = 0; b < BEATS; b++) begin : g_slice
    logic slice_en;
    assign slice_en = beat_we_i && (state_q == ENT_FILL) && (beat_idx_i == BIDX_W'(b));
    always_ff @(posedge clk) begin
      if (slice_en) slice_q[b] <= beat_data_i;
    end
    assign data_o[b*BEAT_W +: BEAT_W] = slice_q[b];
  end

  assign state_o = state_q;
  assign line_o  = line_q;

endmodule

// File: rtl/lfb_top.sv
`timescale 1ns/1ps
module lfb_top
  import lfb_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 512,
  parameter int BEAT_W = 128,
  parameter int TAG_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  parameter int BIDX_W = $clog2(LINE_W / BEAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_line,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_line,
  output logic [TAG_W-1:0]  mem_req_tag,
  input  logic              mem_rsp_valid,
  input  logic [TAG_W-1:0]  mem_rsp_tag,
  input  logic [BIDX_W-1:0] mem_rsp_beat,
  input  logic [BEAT_W-1:0] mem_rsp_data,
  output logic              cwr_valid,
  input  logic              cwr_ready,
  output logic [ADDR_W-1:0] cwr_line,
  output logic [LINE_W-1:0] cwr_data
);

  ent_state_e         st   [N_ENT];
  logic [ADDR_W-1:0]  ln   [N_ENT];
  logic [LINE_W-1:0]  dat  [N_ENT];

  logic [N_ENT-1:0]   free_v, req_v, wr_v, hit_v;
  logic               any_free, hit, take_new;
  logic [TAG_W-1:0]   free_idx, req_pick, wr_idx;

  logic               req_lock_q, req_lock_d;
  logic [TAG_W-1:0]   req_sel_q;
  logic               req_sel_en;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic alloc, req_done, beat_we, wr_done;

    assign free_v[i] = (st[i] == ENT_FREE);
    assign req_v[i]  = (st[i] == ENT_REQ);
    assign wr_v[i]   = (st[i] == ENT_WRITE);
    assign hit_v[i]  = (st[i] != ENT_FREE) && (ln[i] == miss_line);

    assign alloc    = take_new && (free_idx == TAG_W'(i));
    assign req_done = mem_req_valid && mem_req_ready && (mem_req_tag == TAG_W'(i));
    assign beat_we  = mem_rsp_valid && (mem_rsp_tag == TAG_W'(i));
    assign wr_done  = cwr_valid && cwr_ready && (wr_idx == TAG_W'(i));

    lfb_entry #(
      .ADDR_W (ADDR_W),
      .LINE_W (LINE_W),
      .BEAT_W (BEAT_W),
      .BIDX_W (BIDX_W)
    ) i_entry (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc),
      .alloc_line_i (miss_line),
      .req_done_i   (req_done),
      .beat_we_i    (beat_we),
      .beat_idx_i   (mem_rsp_beat),
      .beat_data_i  (mem_rsp_data),
      .wr_done_i    (wr_done),
      .state_o      (st[i]),
      .line_o       (ln[i]),
      .data_o       (dat[i])
    );
  end

  lfb_pick #(.N(N_ENT), .IDX_W(TAG_W)) i_pick_free (
    .req_i (free_v), .any_o (any_free), .idx_o (free_idx)
  );
  lfb_pick #(.N(N_ENT), .IDX_W(TAG_W)) i_pick_req (
    .req_i (req_v), .any_o (mem_req_valid), .idx_o (req_pick)
  );
  lfb_pick #(.N(N_ENT), .IDX_W(TAG_W)) i_pick_wr (
    .req_i (wr_v), .any_o (cwr_valid), .idx_o (wr_idx)
  );

  // miss side
  assign hit        = |hit_v;
  assign miss_ready = any_free;
  assign take_new   = miss_valid && miss_ready && !hit;

  // request side: selection frozen while a request is stalled
  assign req_lock_d  = mem_req_valid && !mem_req_ready;
  assign req_sel_en  = mem_req_valid;
  assign mem_req_tag = req_lock_q ? req_sel_q : req_pick;
  assign mem_req_line = ln[mem_req_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_lock_q <= 1'b0;
      req_sel_q  <= '0;
    end else begin
      req_lock_q <= req_lock_d;
      if (req_sel_en) req_sel_q <= mem_req_tag;
    end
  end

  // cache write side
  assign cwr_line = ln[wr_idx];
  assign cwr_data = dat[wr_idx];

endmodule

// File: rtl/lfb_chk.sv
`timescale 1ns/1ps
module lfb_chk #(
  parameter int N_ENT  = 4,
  parameter int ADDR_W = 26,
  parameter int TAG_W  = 2,
  parameter int BIDX_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_line,
  input logic [TAG_W-1:0]  mem_req_tag,
  input logic              mem_rsp_valid,
  input logic [TAG_W-1:0]  mem_rsp_tag,
  input logic              cwr_valid,
  input logic              cwr_ready,
  input logic [ADDR_W-1:0] cwr_line
);

  localparam int BEATS = 1 << BIDX_W;

  logic [N_ENT-1:0]             pend_q;
  logic [N_ENT-1:0][ADDR_W-1:0] pline_q;
  logic [N_ENT-1:0][BIDX_W:0]   cnt_q;
  logic                         wr_hit, dup;
  logic [TAG_W-1:0]             wr_tag;

  always_comb begin
    wr_hit = 1'b0;
    dup    = 1'b0;
    wr_tag = '0;
    for (int t = 0; t < N_ENT; t++) begin
      if (pend_q[t] && pline_q[t] == cwr_line && cnt_q[t] == (BIDX_W+1)'(BEATS)) begin
        wr_hit = 1'b1;
        wr_tag = TAG_W'(t);
      end
      if (pend_q[t] && pline_q[t] == mem_req_line) dup = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      pline_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (cwr_valid && cwr_ready && wr_hit) pend_q[wr_tag] <= 1'b0;
      if (mem_rsp_valid) cnt_q[mem_rsp_tag] <= cnt_q[mem_rsp_tag] + 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend_q[mem_req_tag]  <= 1'b1;
        pline_q[mem_req_tag] <= mem_req_line;
        cnt_q[mem_req_tag]   <= '0;
      end
    end
  end

  assert_single_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |-> !dup);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_line) && $stable(mem_req_tag)));

  assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pend_q) == N_ENT) |-> !miss_ready);

  assert_write_after_all_beats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_valid && cwr_ready) |-> wr_hit);

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_valid && !cwr_ready) |=> cwr_valid);

endmodule

bind lfb_top lfb_chk #(
  .N_ENT  (N_ENT),
  .ADDR_W (ADDR_W),
  .TAG_W  (TAG_W),
  .BIDX_W (BIDX_W)
) i_lfb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_ready    (miss_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_line  (mem_req_line),
  .mem_req_tag   (mem_req_tag),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_tag   (mem_rsp_tag),
  .cwr_valid     (cwr_valid),
  .cwr_ready     (cwr_ready),
  .cwr_line      (cwr_line)
);

// File: tb/test_lfb_top.sv
`timescale 1ns/1ps
module test_lfb_top;

  localparam int ADDR_W = 26;
  localparam int LINE_W = 512;
  localparam int BEAT_W = 128;

  logic              clk;
  logic              rst_n;
  logic              miss_valid;
  logic              miss_ready;
  logic [ADDR_W-1:0] miss_line;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [ADDR_W-1:0] mem_req_line;
  logic [1:0]        mem_req_tag;
  logic              mem_rsp_valid;
  logic [1:0]        mem_rsp_tag;
  logic [1:0]        mem_rsp_beat;
  logic [BEAT_W-1:0] mem_rsp_data;
  logic              cwr_valid;
  logic              cwr_ready;
  logic [ADDR_W-1:0] cwr_line;
  logic [LINE_W-1:0] cwr_data;

  int nchk;
  int nfail;
  int rq_cnt;
  int nwr;
  logic [ADDR_W-1:0] rq_line [4];
  logic [ADDR_W-1:0] wr_log [512];

  lfb_top i_lfb_top (
    .clk (clk), .rst_n (rst_n),
    .miss_valid (miss_valid), .miss_ready (miss_ready), .miss_line (miss_line),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
    .mem_req_line (mem_req_line), .mem_req_tag (mem_req_tag),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_tag (mem_rsp_tag),
    .mem_rsp_beat (mem_rsp_beat), .mem_rsp_data (mem_rsp_data),
    .cwr_valid (cwr_valid), .cwr_ready (cwr_ready),
    .cwr_line (cwr_line), .cwr_data (cwr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [BEAT_W-1:0] beat_pat(input logic [ADDR_W-1:0] line, input int b);
    return {32'(line), 32'(b), ~32'(line), 32'h5A00_0000 ^ 32'(b * 7 + 1)};
  endfunction

  function automatic logic [LINE_W-1:0] exp_line(input logic [ADDR_W-1:0] line);
    logic [LINE_W-1:0] r;
    for (int b = 0; b < 4; b++) r[b*BEAT_W +: BEAT_W] = beat_pat(line, b);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory-side and cache-side observers
  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      rq_line[mem_req_tag] = mem_req_line;
      rq_cnt++;
    end
    if (rst_n && cwr_valid && cwr_ready) begin
      chk(cwr_data == exp_line(cwr_line), "R5 written line data", cwr_data, exp_line(cwr_line));
      wr_log[nwr] = cwr_line;
      nwr++;
    end
  end

  // all tasks start and end at a falling edge
  task automatic do_miss(input logic [ADDR_W-1:0] line);
    miss_valid = 1'b1;
    miss_line  = line;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic send_beat(input int tag, input int b);
    mem_rsp_valid = 1'b1;
    mem_rsp_tag   = 2'(tag);
    mem_rsp_beat  = 2'(b);
    mem_rsp_data  = beat_pat(rq_line[tag], b);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic fill(input int tag);
    for (int b = 0; b < 4; b++) send_beat(tag, b);
  endtask

  task automatic sweep_one(input int p);
    int avail [4];
    int perm [4];
    int dig [4];
    int n;
    int w0;
    int r0;
    bit ok;
    logic [3:0] done;
    logic [ADDR_W-1:0] base;
    int lo;
    avail = '{0, 1, 2, 3};
    dig = '{p / 6, (p / 2) % 3, p % 2, 0};
    n = 4;
    for (int i = 0; i < 4; i++) begin
      perm[i] = avail[dig[i]];
      for (int j = dig[i]; j < n - 1; j++) avail[j] = avail[j + 1];
      n--;
    end
    base = ADDR_W'(32'h1000 + p * 16);
    cwr_ready = 1'b0;
    for (int k = 0; k < 4; k++) do_miss(base + ADDR_W'(k));
    @(negedge clk);
    @(negedge clk);
    chk(miss_ready == 1'b0, "R4 ready low with four busy entries", LINE_W'(miss_ready), '0);
    ok = 1'b1;
    for (int k = 0; k < 4; k++) if (rq_line[k] != base + ADDR_W'(k)) ok = 1'b0;
    chk(ok, "R1 lowest free entry per miss", LINE_W'(rq_line[0]), LINE_W'(base));
    if (p == 0) begin
      r0 = rq_cnt;
      miss_valid = 1'b1;
      miss_line  = ADDR_W'(32'h3FF_0000);
      @(negedge clk);
      @(negedge clk);
      miss_valid = 1'b0;
      @(negedge clk);
      chk(rq_cnt == r0, "R4 no request while full", LINE_W'(rq_cnt), LINE_W'(r0));
    end
    done = '0;
    for (int i = 0; i < 4; i++) begin
      fill(perm[i]);
      done[perm[i]] = 1'b1;
      lo = 0;
      for (int k = 3; k >= 0; k--) if (done[k]) lo = k;
      chk(cwr_valid && cwr_line == base + ADDR_W'(lo), "R8 lowest complete entry shown",
          LINE_W'(cwr_line), LINE_W'(base + ADDR_W'(lo)));
    end
    w0 = nwr;
    cwr_ready = 1'b1;
    repeat (5) @(negedge clk);
    ok = (nwr == w0 + 4);
    for (int k = 0; k < 4; k++) if (wr_log[w0 + k] != base + ADDR_W'(k)) ok = 1'b0;
    chk(ok, "R8 writes drain in ascending entry order", LINE_W'(wr_log[w0]), LINE_W'(base));
    chk(miss_ready == 1'b1, "R7 entries free after writes", LINE_W'(miss_ready), LINE_W'(1));
  endtask

  initial begin
    int r0;
    int w0;
    nchk = 0; nfail = 0; rq_cnt = 0; nwr = 0;
    rst_n = 1'b0;
    miss_valid = 1'b0; miss_line = '0;
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0; mem_rsp_tag = '0; mem_rsp_beat = '0; mem_rsp_data = '0;
    cwr_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready && !mem_req_valid && !cwr_valid, "R9 reset state",
        LINE_W'({miss_ready, mem_req_valid, cwr_valid}), LINE_W'(3'b100));

    // single miss
    do_miss(26'h100);
    chk(mem_req_valid && mem_req_line == 26'h100 && mem_req_tag == 2'd0, "R1 request for miss",
        LINE_W'({mem_req_valid, mem_req_tag, mem_req_line}), LINE_W'({1'b1, 2'd0, 26'h100}));
    @(negedge clk);
    chk(rq_cnt == 1 && !mem_req_valid, "R1 exactly one request", LINE_W'(rq_cnt), LINE_W'(1));
    for (int b = 0; b < 3; b++) send_beat(0, b);
    chk(!cwr_valid, "R6 no write before fourth beat", LINE_W'(cwr_valid), '0);
    send_beat(0, 3);
    chk(cwr_valid && cwr_line == 26'h100, "R6 write after fourth beat",
        LINE_W'({cwr_valid, cwr_line}), LINE_W'({1'b1, 26'h100}));
    @(negedge clk);
    chk(nwr == 1 && miss_ready, "R7 written and freed", LINE_W'(nwr), LINE_W'(1));

    // stalled request with a second waiter, then interleaved beats
    mem_req_ready = 1'b0;
    do_miss(26'h200);
    chk(mem_req_valid && mem_req_tag == 2'd0 && mem_req_line == 26'h200, "R2 request presented",
        LINE_W'(mem_req_line), LINE_W'(26'h200));
    do_miss(26'h300);
    chk(mem_req_valid && mem_req_tag == 2'd0 && mem_req_line == 26'h200, "R2 request held",
        LINE_W'(mem_req_line), LINE_W'(26'h200));
    @(negedge clk);
    chk(mem_req_valid && mem_req_tag == 2'd0 && mem_req_line == 26'h200, "R2 request still held",
        LINE_W'(mem_req_line), LINE_W'(26'h200));
    r0 = rq_cnt;
    mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rq_cnt == r0 + 2 && rq_line[0] == 26'h200 && rq_line[1] == 26'h300,
        "R1 two requests with entry tags", LINE_W'(rq_cnt), LINE_W'(r0 + 2));
    w0 = nwr;
    for (int b = 0; b < 4; b++) begin
      send_beat(1, b);
      send_beat(0, b);
    end
    @(negedge clk);
    @(negedge clk);
    chk(nwr == w0 + 2 && wr_log[w0] == 26'h300 && wr_log[w0 + 1] == 26'h200,
        "R5 interleaved fills both written", LINE_W'(wr_log[w0]), LINE_W'(26'h300));

    // merge of a repeated miss
    do_miss(26'h400);
    @(negedge clk);
    r0 = rq_cnt;
    chk(miss_ready, "R3 ready for merge", LINE_W'(miss_ready), LINE_W'(1));
    do_miss(26'h400);
    @(negedge clk);
    @(negedge clk);
    chk(rq_cnt == r0 && !mem_req_valid, "R3 merged miss issues no request",
        LINE_W'(rq_cnt), LINE_W'(r0));
    w0 = nwr;
    fill(0);
    @(negedge clk);
    @(negedge clk);
    chk(nwr == w0 + 1 && wr_log[w0] == 26'h400, "R3 merged line written once",
        LINE_W'(nwr - w0), LINE_W'(1));

    // every completion order of four concurrent fills
    for (int p = 0; p < 24; p++) sweep_one(p);

    // reset in the middle of fills
    do_miss(26'h500);
    do_miss(26'h600);
    @(negedge clk);
    send_beat(0, 0);
    send_beat(0, 1);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready && !mem_req_valid && !cwr_valid, "R9 state after reset",
        LINE_W'({miss_ready, mem_req_valid, cwr_valid}), LINE_W'(3'b100));
    do_miss(26'h700);
    chk(mem_req_valid && mem_req_tag == 2'd0 && mem_req_line == 26'h700, "R9 entry 0 reused",
        LINE_W'({mem_req_tag, mem_req_line}), LINE_W'({2'd0, 26'h700}));
    @(negedge clk);
    for (int b = 0; b < 3; b++) send_beat(0, b);
    chk(!cwr_valid, "R9 old beats dropped", LINE_W'(cwr_valid), '0);
    w0 = nwr;
    send_beat(0, 3);
    @(negedge clk);
    chk(nwr == w0 + 1 && wr_log[w0] == 26'h700, "R9 fill after reset written",
        LINE_W'(nwr - w0), LINE_W'(1));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule